// File: doc/BRIEF.md
# Serial Flash Page Program Loader

This block is the page-program part of a serial-flash slave that runs in a system clock domain. It watches the SPI pins (mode 0, MSB first) and takes the program command: opcode `02h`, then three address bytes, then data bytes. The data bytes go into a 256-byte page buffer that also records which columns were filled. When chip select rises, the buffer is merged into the target page of a small internal byte array, one column per clock. The block then stays busy for a fixed number of further cycles before it returns to idle.

The enclosing slave supplies the write-enable latch state and a per-page protection mask. It receives a one-cycle pulse that tells it to clear the write-enable latch. A combinational read port lets neighbouring read logic, or a bench, observe the array. All three SPI inputs pass through two-stage synchronisers. SCK must therefore run slower than about a quarter of the system clock, and chip select must rise at least one system clock after the last SCK rising edge.

Top module: `spi_page_loader`

## Requirements
- R1: A session whose first complete byte is `02h`, followed by three address bytes (most significant first) and at least one data byte, programs the array. A session with any other first byte leaves the array unchanged and produces no `wel_clr` pulse.
- R2: Data byte k (k = 0, 1, …) goes to column (A[7:0] + k) mod 256 of page A[ADDR_W-1:8], so the bytes wrap within the page and never reach the next page. Address bits at and above ADDR_W are ignored.
- R3: When more than 256 data bytes are sent, a later byte replaces an earlier byte that fell in the same column, so the last 256 bytes received are the ones programmed.
- R4: Trailing bits that do not complete a byte before chip select rises are discarded.
- R5: Only columns that received a byte in the session are written. Each written location becomes the bitwise AND of its old value and the received byte.
- R6: If `wel_in` is 0 when chip select rises, the program is rejected. The array is unchanged, `busy` stays 0, and `wel_clr` pulses for one cycle.
- R7: If the target page's bit in `wp_pages` is 1 when chip select rises, the program is rejected in the same way as R6.
- R8: An accepted program raises `busy` for exactly 256 + PROG_CYCLES cycles. `wel_clr` pulses for one cycle in the cycle `busy` falls.
- R9: A session whose chip select falls while `busy` is 1 is ignored entirely, even after `busy` drops.
- R10: After reset, `busy` and `wel_clr` are 0 and every array byte reads `FFh`.
- R11: A program session that ends with a complete address but no complete data byte changes nothing. It does not raise `busy` and does pulse `wel_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in, sampled on SCK rising edge |
| wel_in | input | 1 | Write-enable latch state from the slave |
| wp_pages | input | 2**(ADDR_W-8) | Per-page protection mask, 1 = protected |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Program in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The hardest state to reach from the ports is a new chip-select session that begins while a program is still in progress. The bench covers it by ending one program session without waiting, then at once opening a second, fully valid session. It uses a long program interval so that the second session ends before `busy` falls. Column wrap, and a session longer than one page, are driven directly. Random sessions then mix opcodes, lengths, ragged bit counts, enable and protection states against a bench-side array model.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int COL_W      = 8;
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam logic [7:0] OPC_PROGRAM = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_COMMIT, S_WAIT} pp_state_e;

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c);
    return c + COL_W'(1);
  endfunction

  function automatic logic [7:0] and_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction
endpackage

// File: rtl/pp_spi_rx.sv
module pp_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       cs_fall,
  output logic       cs_rise
);
  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sck_rise;

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign cs_fall  = ~cs_q[1] & cs_q[2];
  assign cs_rise  = cs_q[1] & ~cs_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_q[1]) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, mosi_q[1]};
        end
      end
    end
  end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf
  import pp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  input  logic [COL_W-1:0] rcol,
  output logic [7:0]       rdata,
  output logic             rvld
);
  logic [7:0]            store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;

  always_ff @(posedge clk) begin
    if (we) store[wcol] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   filled <= '0;
    else if (clr) filled <= '0;
    else if (we)  filled[wcol] <= 1'b1;
  end

  assign rdata = store[rcol];
  assign rvld  = filled[rcol];
endmodule

// File: rtl/pp_array.sv
module pp_array
  import pp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= and_merge(cells[waddr], wdata);
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_page_loader.sv
module spi_page_loader
  import pp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sck,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  input  logic                        wel_in,
  input  logic [(1<<(ADDR_W-8))-1:0]  wp_pages,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [7:0]                  rd_data,
  output logic                        busy,
  output logic                        wel_clr
);
  localparam int PG_W     = ADDR_W - COL_W;
  localparam int CNT_W    = $clog2(PROG_CYCLES + 1);
  localparam int BUSY_LEN = PAGE_BYTES + PROG_CYCLES;

  logic             byte_vld, cs_fall, cs_rise;
  logic [7:0]       byte_data;
  logic             sess_act;
  logic [7:0]       opcode;
  logic [2:0]       nbytes;
  logic [23:0]      addr;
  logic [COL_W-1:0] col;
  logic [PG_W-1:0]  page;
  logic             page_prot;
  pp_state_e        state;
  logic [COL_W-1:0] idx;
  logic [CNT_W-1:0] wait_cnt;
  logic             buf_clr, buf_we, is_prog_end, commit_start, reject;
  logic [7:0]       buf_rdata;
  logic             buf_rvld;
  logic             arr_we;
  logic [ADDR_W-1:0] arr_addr;

  pp_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  assign page         = addr[ADDR_W-1:COL_W];
  assign page_prot    = wp_pages[page];
  assign buf_clr      = cs_fall && (state == S_IDLE);
  assign buf_we       = byte_vld && sess_act && (nbytes >= 3'd4) && (opcode == OPC_PROGRAM);
  assign is_prog_end  = cs_rise && sess_act && (opcode == OPC_PROGRAM) && (nbytes >= 3'd4);
  assign commit_start = is_prog_end && (nbytes == 3'd5) && wel_in && !page_prot;
  assign reject       = is_prog_end && !commit_start;

  pp_page_buf u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .wcol(col), .wdata(byte_data),
    .rcol(idx), .rdata(buf_rdata), .rvld(buf_rvld)
  );

  assign arr_we   = (state == S_COMMIT) && buf_rvld;
  assign arr_addr = {page, idx};

  pp_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr), .wdata(buf_rdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // command capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_act <= 1'b0;
      opcode   <= '0;
      nbytes   <= '0;
      addr     <= '0;
      col      <= '0;
    end else begin
      if (cs_fall) begin
        sess_act <= (state == S_IDLE);
        nbytes   <= '0;
        opcode   <= '0;
      end else if (cs_rise) begin
        sess_act <= 1'b0;
      end else if (byte_vld && sess_act) begin
        if (nbytes != 3'd5) nbytes <= nbytes + 3'd1;
        case (nbytes)
          3'd0:       opcode <= byte_data;
          3'd1, 3'd2: addr   <= {addr[15:0], byte_data};
          3'd3: begin
            addr <= {addr[15:0], byte_data};
            col  <= byte_data;
          end
          default:    col <= next_col(col);
        endcase
      end
    end
  end

  // commit sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      wait_cnt <= '0;
      wel_clr  <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      case (state)
        S_IDLE: begin
          if (commit_start) begin
            state <= S_COMMIT;
            idx   <= '0;
          end else if (reject) begin
            wel_clr <= 1'b1;
          end
        end
        S_COMMIT: begin
          idx <= next_col(idx);
          if (idx == COL_W'(PAGE_BYTES - 1)) begin
            state    <= S_WAIT;
            wait_cnt <= '0;
          end
        end
        S_WAIT: begin
          wait_cnt <= wait_cnt + CNT_W'(1);
          if (wait_cnt == CNT_W'(PROG_CYCLES - 1)) begin
            state   <= S_IDLE;
            wel_clr <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/pp_loader_chk.sv
module pp_loader_chk #(
  parameter int BUSY_LEN = 288
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wel_clr,
  input logic wel_in,
  input logic page_prot,
  input logic commit_start,
  input logic reject,
  input logic arr_we
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 32'd1;
    else           bcnt <= '0;
  end

  p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> wel_in);
  p_start_unprotected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> !page_prot);
  p_reject_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (wel_clr && !busy));
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> busy);
  p_write_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BUSY_LEN));
endmodule

bind spi_page_loader pp_loader_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel_clr(wel_clr), .wel_in(wel_in),
  .page_prot(page_prot), .commit_start(commit_start), .reject(reject), .arr_we(arr_we)
);

// File: tb/test_spi_page_loader.sv
`timescale 1ns/1ps
module test_spi_page_loader;
  localparam int ADDR_W = 10;
  localparam int PROG   = 400;
  localparam int NPG    = 1 << (ADDR_W - 8);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BLEN   = 256 + PROG;
  localparam int HALF   = 4;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, wel = 0;
  logic [NPG-1:0] wp = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, wel_clr;

  spi_page_loader #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) i_spi_page_loader (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wel_in(wel), .wp_pages(wp), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .wel_clr(wel_clr)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int pulses = 0, bcycles = 0, exp_pulses = 0, exp_bcycles = 0;
  int cyc = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] tx [600];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && wel_clr) pulses++;
    if (rst_n && busy) bcycles++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int col_of(input logic [7:0] start, input int k);
    return (int'(start) + k) % 256;
  endfunction

  task automatic apply_model(input int n, input logic w, input logic [NPG-1:0] prot);
    logic [7:0] stage [256];
    bit sv [256];
    int pg;
    if (n < 1 || tx[0] != 8'h02 || n < 4) return;
    pg = int'(tx[2][ADDR_W-9:0]);
    if (n >= 5 && w && !prot[pg]) begin
      for (int c = 0; c < 256; c++) sv[c] = 0;
      for (int k = 4; k < n; k++) begin
        stage[col_of(tx[3], k-4)] = tx[k];
        sv[col_of(tx[3], k-4)] = 1;
      end
      for (int c = 0; c < 256; c++)
        if (sv[c]) model[pg*256 + c] = model[pg*256 + c] & stage[c];
      exp_bcycles += BLEN;
    end
    exp_pulses++;
  endtask

  task automatic bit_out(input logic b);
    mosi = b;
    repeat (HALF) @(posedge clk);
    sck = 1;
    repeat (HALF) @(posedge clk);
    sck = 0;
  endtask

  task automatic session(input int n, input int extra, input bit nowait);
    cs_n = 0;
    repeat (HALF) @(posedge clk);
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) bit_out(tx[k][b]);
    for (int b = 0; b < extra; b++) bit_out(1'b0);
    repeat (HALF) @(posedge clk);
    cs_n = 1;
    repeat (8) @(posedge clk);
    if (!nowait) begin
      while (busy) @(posedge clk);
      repeat (4) @(posedge clk);
    end
  endtask

  task automatic run(input int n, input int extra, input logic w, input logic [NPG-1:0] prot,
                     input string req);
    wel = w; wp = prot;
    apply_model(n, w, prot);
    session(n, extra, 0);
    check_array(req);
  endtask

  task automatic check_array(input string req);
    int bad = -1;
    logic [7:0] got = 0;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ADDR_W'(a);
      #1;
      if (bad < 0 && rd_data !== model[a]) begin bad = a; got = rd_data; end
    end
    chk(bad < 0, {req, " array"}, bad < 0 ? 0 : int'(got), bad < 0 ? 0 : int'(model[bad]));
    chk(pulses == exp_pulses, {req, " wel_clr pulses"}, pulses, exp_pulses);
    chk(bcycles == exp_bcycles, {req, " busy cycles R8"}, bcycles, exp_bcycles);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a);
    tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0, "R10 busy", busy, 0);
    chk(wel_clr === 1'b0, "R10 wel_clr", wel_clr, 0);
    check_array("R10");

    // R1 basic program, upper address bits ignored (R2)
    hdr(8'h02, 24'hA501F0);
    for (int k = 4; k < 9; k++) tx[k] = 8'h10 + 8'(k);
    run(9, 0, 1, '0, "R1 basic");
    // R1 other opcode
    hdr(8'h03, 24'h000020);
    for (int k = 4; k < 9; k++) tx[k] = 8'h00;
    run(9, 0, 1, '0, "R1 other opcode");
    // R2 wrap within page
    hdr(8'h02, 24'h0002FC);
    for (int k = 4; k < 14; k++) tx[k] = 8'($urandom);
    run(14, 0, 1, '0, "R2 wrap");
    // R3 more than a page
    hdr(8'h02, 24'h000310);
    for (int k = 4; k < 304; k++) tx[k] = 8'($urandom);
    run(304, 0, 1, '0, "R3 last 256");
    // R4 partial final byte
    hdr(8'h02, 24'h000040);
    for (int k = 4; k < 7; k++) tx[k] = 8'h5A;
    run(7, 5, 1, '0, "R4 partial");
    // R5 AND merge onto earlier data
    hdr(8'h02, 24'h0001F1);
    tx[4] = 8'hF0; tx[5] = 8'h0F;
    run(6, 0, 1, '0, "R5 and merge");
    // R6 no write enable
    hdr(8'h02, 24'h000000);
    tx[4] = 8'h00;
    run(5, 0, 0, '0, "R6 wel low");
    // R7 protected page
    hdr(8'h02, 24'h000180);
    tx[4] = 8'h00;
    run(5, 0, 1, 4'b0010, "R7 protected");
    // R11 address only
    hdr(8'h02, 24'h000080);
    run(4, 6, 1, '0, "R11 no data");
    // R9 session during busy
    hdr(8'h02, 24'h000050);
    tx[4] = 8'h12;
    wel = 1; wp = '0;
    apply_model(5, 1, '0);
    session(5, 0, 1);
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    hdr(8'h02, 24'h000060);
    tx[4] = 8'h00;
    session(5, 0, 0);
    check_array("R9 ignored while busy");

    // random mix
    for (int r = 0; r < 14; r++) begin
      int n = 1 + int'($urandom % 40);
      int ex = int'($urandom % 8);
      logic w = ($urandom % 5) != 0;
      logic [NPG-1:0] p = NPG'($urandom) & NPG'($urandom);
      hdr((($urandom % 4) == 0) ? 8'($urandom) : 8'h02, 24'($urandom));
      for (int k = 4; k < n; k++) tx[k] = 8'($urandom);
      run(n, ex, w, p, "R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule